// File: doc/BRIEF.md
# Serial Display Command Loader

This block receives commands for a two-grid vacuum fluorescent display driver over a three-wire serial link made of a chip-select line, a data line and a shift clock. While the chip-select is high, each rising shift-clock edge moves one data bit into a 64-stage frame register. When the chip-select falls, four mode bits read from fixed positions in that register decide what happens. The block can take a new 60-bit display word, take an 11-bit digital dimming word, or switch the dimming source between digital dimming and conversion of an external PWM signal. Some codes combine a source change with a new display word.

The three serial lines are asynchronous to the block's own clock. Each is passed through a synchronizer, and the edges are detected in the system clock domain. A serial output gives back each accepted bit 64 shift edges after it went in, so further drivers can be chained on the same link. A frame that carries display data is 64 bits long. A frame that carries only a dimming word or a source change is 16 bits long. This works because the mode field and the dimming field both sit in the upper part of the register, which a short frame also fills.

Top module: `vfd_cmd_loader`

## Requirements
- R1: A bit is accepted only on a rising edge of `ser_clk` while `ser_sel` is high. It enters frame position 63 (0-based), and every stored bit moves down by one position. Shift-clock edges seen while `ser_sel` is low change nothing.
- R2: `disp_word`, `dim_word` and `pwm_src` change only because `ser_sel` falls, and they settle within 4 system clock cycles after the synchronized fall.
- R3: The mode code is frame positions 51..48, read as M3..M0. Code 0000 loads the display word. `disp_word[47:0]` takes frame positions 47..0 and `disp_word[59:48]` takes positions 63..52. In a 64-bit frame the serial order is therefore D0..D47, then M0..M3, then D48..D59.
- R4: Code 0001 loads `dim_word` from frame positions 63..53, with bit 10 at position 63. In a 16-bit frame the serial order is M0..M3, one unused bit, then dimming bits 0 to 10. The display word and the source are left unchanged.
- R5: Code 0100 loads the display word as in R3 and sets `pwm_src` to 0 (digital dimming). Code 0010 does the same but sets `pwm_src` to 1 (PWM conversion).
- R6: Code 0101 sets `pwm_src` to 0 and code 0011 sets it to 1. Neither code changes the display word or the dimming word.
- R7: Every other mode code leaves `disp_word`, `dim_word` and `pwm_src` unchanged.
- R8: `ser_out` changes only on an accepted shift edge. After the n-th accepted bit since reset, it shows bit n-64, or 0 while n is 64 or less.
- R9: While `rst_n` is low, the frame register, `ser_out`, `disp_word` and `dim_word` are cleared and `pwm_src` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_sel | input | 1 | Asynchronous chip-select; high enables shifting, falling edge commits |
| ser_clk | input | 1 | Asynchronous shift clock; rising edge accepts a bit |
| ser_dat | input | 1 | Asynchronous serial data |
| ser_out | output | 1 | Cascade output, accepted data delayed by 64 shifts |
| disp_word | output | 60 | Latched display word |
| dim_word | output | 11 | Latched digital dimming word |
| pwm_src | output | 1 | Dimming source: 1 = PWM conversion, 0 = digital dimming |

## Verification
The bench builds the block with its default parameters: a 64-bit frame, the mode field at position 48, an 11-bit dimming word and two synchronizer stages. This is already small enough that all sixteen mode codes can be swept in full 64-bit frames, each with its own display pattern. After the sweep come short frames carrying the dimming word at its extremes and middle values, short frames with source-only and unlisted codes, shift pulses sent with the chip-select low, and a reset in the middle of the run. The cascade output is compared after every accepted bit against a 64-deep history of the stream, so the first 64 shifts (zeros) and the wrap-through of real data are both covered.

// File: rtl/vfd_cmd_pkg.sv
// Package: shared mode-field constants and the command decode used by the
// latch bank. Assumes a 4-bit mode field; unlisted codes decode to no action.
package vfd_cmd_pkg;

    localparam int MODE_W = 4;

    localparam logic [MODE_W-1:0] CMD_DISP      = 4'b0000;
    localparam logic [MODE_W-1:0] CMD_DIM       = 4'b0001;
    localparam logic [MODE_W-1:0] CMD_PWM_DISP  = 4'b0010;
    localparam logic [MODE_W-1:0] CMD_PWM       = 4'b0011;
    localparam logic [MODE_W-1:0] CMD_DIG_DISP  = 4'b0100;
    localparam logic [MODE_W-1:0] CMD_DIG       = 4'b0101;

    typedef struct packed {
        logic take_disp;
        logic take_dim;
        logic set_src;
        logic src_pwm;
    } cmd_action_t;

    // Translate a mode code into the set of latch updates it requests.
    function automatic cmd_action_t decode_cmd(input logic [MODE_W-1:0] code);
        cmd_action_t a;
        a = '0;
        case (code)
            CMD_DISP:     a.take_disp = 1'b1;
            CMD_DIM:      a.take_dim  = 1'b1;
            CMD_PWM_DISP: begin a.take_disp = 1'b1; a.set_src = 1'b1; a.src_pwm = 1'b1; end
            CMD_PWM:      begin a.set_src = 1'b1; a.src_pwm = 1'b1; end
            CMD_DIG_DISP: begin a.take_disp = 1'b1; a.set_src = 1'b1; end
            CMD_DIG:      a.set_src = 1'b1;
            default:      a = '0;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/vfd_in_sync.sv
// Module: multi-stage synchronizer for a vector of independent asynchronous
// inputs. Assumes each bit is a slow level signal, so bits need not be
// coherent with each other; reset drives every stage to 0.
module vfd_in_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_q
);

    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the raw inputs into the first stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= async_in;
                end
            end else begin : g_next
                // Pass the value one stage further down the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign sync_q = chain[STAGES-1];

endmodule

// File: rtl/vfd_shift_path.sv
// Module: frame shift register with cascade output. A new bit enters at the
// top position and everything moves down one place; the bit leaving position
// 0 is registered onto the cascade output. Assumes shift is a one-cycle pulse.
module vfd_shift_path #(
    parameter int FRAME_W = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift,
    input  logic               din,
    output logic [FRAME_W-1:0] frame_q,
    output logic               dout_q
);

    // Move the frame down by one place and export the bit that falls out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= '0;
            dout_q  <= 1'b0;
        end else if (shift) begin
            frame_q <= {din, frame_q[FRAME_W-1:1]};
            dout_q  <= frame_q[0];
        end
    end

endmodule

// File: rtl/vfd_latch_bank.sv
// Module: command decode and output latches. On a commit pulse it reads the
// mode field at a fixed frame position and updates the display word, the
// dimming word and the source flag as the code requests. Assumes the mode
// field lies inside the display span, and the dimming field at the top.
module vfd_latch_bank #(
    parameter int FRAME_W  = 64,
    parameter int MODE_POS = 48,
    parameter int DIM_W    = 11
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      commit,
    input  logic [FRAME_W-1:0]                        frame,
    output logic [FRAME_W-vfd_cmd_pkg::MODE_W-1:0]    disp_q,
    output logic [DIM_W-1:0]                          dim_q,
    output logic                                      pwm_src_q
);

    import vfd_cmd_pkg::*;

    localparam int DISP_W  = FRAME_W - MODE_W;
    localparam int DIM_LSB = FRAME_W - DIM_W;

    logic [DISP_W-1:0] disp_next;
    logic [DIM_W-1:0]  dim_next;
    cmd_action_t       act;

    // Gather display bits around the embedded mode field.
    generate
        for (genvar i = 0; i < DISP_W; i++) begin : g_disp_map
            if (i < MODE_POS) begin : g_low
                assign disp_next[i] = frame[i];
            end else begin : g_high
                assign disp_next[i] = frame[i + MODE_W];
            end
        end
    endgenerate

    assign dim_next = frame[DIM_LSB +: DIM_W];

    // Decode the mode field of the current frame.
    always_comb begin
        act = decode_cmd(frame[MODE_POS +: MODE_W]);
    end

    // Update the display latch on a commit that carries display data.
    always_ff @(posedge clk) begin
        if (!rst_n)                      disp_q <= '0;
        else if (commit && act.take_disp) disp_q <= disp_next;
    end

    // Update the dimming latch on a commit that carries a dimming word.
    always_ff @(posedge clk) begin
        if (!rst_n)                     dim_q <= '0;
        else if (commit && act.take_dim) dim_q <= dim_next;
    end

    // Update the dimming source on a commit that selects one.
    always_ff @(posedge clk) begin
        if (!rst_n)                     pwm_src_q <= 1'b1;
        else if (commit && act.set_src) pwm_src_q <= act.src_pwm;
    end

endmodule

// File: rtl/vfd_cmd_loader.sv
// Module: top of the serial display command loader. Synchronizes the three
// serial lines, detects shift-clock rises while selected and select falls,
// and drives the shift path and latch bank from those pulses. Assumes the
// serial clock is slower than a few system clock periods per phase.
module vfd_cmd_loader #(
    parameter int FRAME_W     = 64,
    parameter int MODE_POS    = 48,
    parameter int DIM_W       = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   ser_sel,
    input  logic                                   ser_clk,
    input  logic                                   ser_dat,
    output logic                                   ser_out,
    output logic [FRAME_W-vfd_cmd_pkg::MODE_W-1:0] disp_word,
    output logic [DIM_W-1:0]                       dim_word,
    output logic                                   pwm_src
);

    localparam int PIN_W   = 3;
    localparam int P_DAT   = 0;
    localparam int P_CLK   = 1;
    localparam int P_SEL   = 2;

    logic [PIN_W-1:0]   pins_s;
    logic               sel_d;
    logic               sck_d;
    logic               sh_en;
    logic               cs_fall;
    logic [FRAME_W-1:0] frame_q;

    vfd_in_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({ser_sel, ser_clk, ser_dat}),
        .sync_q   (pins_s)
    );

    // Remember the previous synchronized select and clock levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_d <= 1'b0;
            sck_d <= 1'b0;
        end else begin
            sel_d <= pins_s[P_SEL];
            sck_d <= pins_s[P_CLK];
        end
    end

    assign sh_en   = pins_s[P_CLK] & ~sck_d & pins_s[P_SEL];
    assign cs_fall = sel_d & ~pins_s[P_SEL];

    vfd_shift_path #(.FRAME_W(FRAME_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift   (sh_en),
        .din     (pins_s[P_DAT]),
        .frame_q (frame_q),
        .dout_q  (ser_out)
    );

    vfd_latch_bank #(.FRAME_W(FRAME_W), .MODE_POS(MODE_POS), .DIM_W(DIM_W)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (cs_fall),
        .frame     (frame_q),
        .disp_q    (disp_word),
        .dim_q     (dim_word),
        .pwm_src_q (pwm_src)
    );

endmodule

// File: rtl/vfd_cmd_loader_chk.sv
// Module: assertion checker for the command loader, bound to the top module.
// Watches the internal shift and commit pulses against the output ports.
module vfd_cmd_loader_chk #(
    parameter int FRAME_W  = 64,
    parameter int MODE_POS = 48,
    parameter int DIM_W    = 11
) (
    input logic                                   clk,
    input logic                                   rst_n,
    input logic                                   sh_en,
    input logic                                   cs_fall,
    input logic [FRAME_W-1:0]                     frame_q,
    input logic                                   ser_out,
    input logic [FRAME_W-vfd_cmd_pkg::MODE_W-1:0] disp_word,
    input logic [DIM_W-1:0]                       dim_word,
    input logic                                   pwm_src
);

    logic [3:0] code;
    assign code = frame_q[MODE_POS +: 4];

    // R9
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (disp_word == '0 && dim_word == '0 && pwm_src && !ser_out));

    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sh_en |=> $stable(frame_q));

    // R1
    shift_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sh_en |=> frame_q[FRAME_W-2:0] == $past(frame_q[FRAME_W-1:1]));

    // R8
    cascade_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sh_en |=> ser_out == $past(frame_q[0]));

    // R8
    cascade_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sh_en |=> $stable(ser_out));

    // R2
    commit_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_fall |=> ($stable(disp_word) && $stable(dim_word) && $stable(pwm_src)));

    // R4
    dim_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_fall && code == 4'b0001) |=>
        (dim_word == $past(frame_q[FRAME_W-1 -: DIM_W]) && $stable(disp_word) && $stable(pwm_src)));

    // R5
    src_pwm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_fall && (code == 4'b0010 || code == 4'b0011)) |=> pwm_src);

    // R5
    src_dig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_fall && (code == 4'b0100 || code == 4'b0101)) |=> !pwm_src);

    // R6
    src_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_fall && (code == 4'b0011 || code == 4'b0101)) |=>
        ($stable(disp_word) && $stable(dim_word)));

    // R7
    unlisted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_fall && code[3:1] != 3'b000 && code[3:1] != 3'b001 && code[3:1] != 3'b010) |=>
        ($stable(disp_word) && $stable(dim_word) && $stable(pwm_src)));

endmodule

bind vfd_cmd_loader vfd_cmd_loader_chk #(
    .FRAME_W  (FRAME_W),
    .MODE_POS (MODE_POS),
    .DIM_W    (DIM_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sh_en     (sh_en),
    .cs_fall   (cs_fall),
    .frame_q   (frame_q),
    .ser_out   (ser_out),
    .disp_word (disp_word),
    .dim_word  (dim_word),
    .pwm_src   (pwm_src)
);

// File: tb/vfd_cmd_loader_bench.sv
// Bench: sweeps every mode code in full frames, dimming values in short
// frames, ignored shift pulses and a mid-run reset; compares the cascade
// output after every accepted bit against a history of the stream.
module vfd_cmd_loader_bench;

    logic        clk = 1'b0;
    logic        rst_n, ser_sel, ser_clk, ser_dat;
    logic        ser_out;
    logic [59:0] disp_word;
    logic [10:0] dim_word;
    logic        pwm_src;

    always #4 clk = ~clk;

    vfd_cmd_loader u_vfd_cmd_loader (
        .clk(clk), .rst_n(rst_n), .ser_sel(ser_sel), .ser_clk(ser_clk),
        .ser_dat(ser_dat), .ser_out(ser_out), .disp_word(disp_word),
        .dim_word(dim_word), .pwm_src(pwm_src)
    );

    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 0;
    logic [63:0] img;
    logic [59:0] e_disp;
    logic [10:0] e_dim;
    logic        e_src;
    logic        hist [0:8191];
    int          nsh;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic model_reset();
        img = '0; e_disp = '0; e_dim = '0; e_src = 1'b1; nsh = 0;
    endtask

    task automatic check_outputs(input string req);
        check(req, {4'h0, e_disp}, {4'h0, disp_word});
        check(req, {53'h0, e_dim}, {53'h0, dim_word});
        check(req, {63'h0, e_src}, {63'h0, pwm_src});
    endtask

    // One accepted bit, then the cascade output compared with the history (R8).
    task automatic send_bit(input logic b);
        logic exp_o;
        @(negedge clk) ser_dat = b;
        wait_cyc(3);
        ser_clk = 1'b1;
        wait_cyc(4);
        ser_clk = 1'b0;
        wait_cyc(4);
        if (nsh < 8192) hist[nsh] = b;
        nsh++;
        img = {b, img[63:1]};
        exp_o = (nsh > 64) ? hist[nsh-65] : 1'b0;
        check("R8", {63'h0, exp_o}, {63'h0, ser_out});
    endtask

    function automatic string tag_of(input logic [3:0] m);
        case (m)
            4'b0000: return "R3";
            4'b0001: return "R4";
            4'b0010, 4'b0100: return "R5";
            4'b0011, 4'b0101: return "R6";
            default: return "R7";
        endcase
    endfunction

    // Expected latch update for a committed frame, from the R3..R7 table.
    task automatic model_commit();
        logic [3:0] m;
        m = img[51:48];
        case (m)
            4'b0000: e_disp = {img[63:52], img[47:0]};
            4'b0001: e_dim  = img[63:53];
            4'b0010: begin e_disp = {img[63:52], img[47:0]}; e_src = 1'b1; end
            4'b0011: e_src = 1'b1;
            4'b0100: begin e_disp = {img[63:52], img[47:0]}; e_src = 1'b0; end
            4'b0101: e_src = 1'b0;
            default: ;
        endcase
    endtask

    task automatic send_frame(input logic [63:0] bits, input int n);
        @(negedge clk) ser_sel = 1'b1;
        wait_cyc(4);
        for (int i = 0; i < n; i++) send_bit(bits[i]);
        wait_cyc(2);
        ser_sel = 1'b0;
        wait_cyc(8);
        model_commit();
        check_outputs(tag_of(img[51:48]));
    endtask

    // Serial order for a 64-bit frame: D0..D47, M0..M3, D48..D59 (R3).
    function automatic logic [63:0] frame64(input logic [59:0] d, input logic [3:0] m);
        logic [63:0] r;
        for (int i = 0; i < 64; i++) begin
            if (i < 48)      r[i] = d[i];
            else if (i < 52) r[i] = m[i-48];
            else             r[i] = d[i-4];
        end
        return r;
    endfunction

    // Serial order for a 16-bit frame: M0..M3, unused, dim bit0..bit10 (R4).
    function automatic logic [63:0] frame16(input logic [10:0] v, input logic [3:0] m);
        logic [63:0] r;
        r = '0;
        r[3:0]  = m;
        r[4]    = 1'b0;
        r[15:5] = v;
        return r;
    endfunction

    task automatic print_summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            print_summary();
            $finish;
        end
    end

    initial begin
        logic [63:0] pat;
        logic        held;
        rst_n = 1'b0; ser_sel = 1'b0; ser_clk = 1'b0; ser_dat = 1'b0;
        model_reset();
        wait_cyc(4);
        // R9: reset state
        check("R9", {4'h0, disp_word}, 64'h0);
        check("R9", {53'h0, dim_word}, 64'h0);
        check("R9", {63'h0, pwm_src}, 64'h1);
        check("R9", {63'h0, ser_out}, 64'h0);
        @(negedge clk) rst_n = 1'b1;
        wait_cyc(4);

        // R3 R5 R6 R7: every mode code in a full frame with its own pattern.
        for (int m = 0; m < 16; m++) begin
            pat = 64'h9E37_79B9_7F4A_7C15 * (m + 3);
            send_frame(frame64(pat[59:0], m[3:0]), 64);
        end

        // R4: dimming word extremes and middle values in short frames.
        send_frame(frame16(11'h7FF, 4'b0001), 16);
        send_frame(frame16(11'h000, 4'b0001), 16);
        send_frame(frame16(11'h001, 4'b0001), 16);
        send_frame(frame16(11'h400, 4'b0001), 16);
        send_frame(frame16(11'h555, 4'b0001), 16);

        // R6 R7: source-only and unlisted codes in short frames.
        send_frame(frame16(11'h2AA, 4'b0101), 16);
        send_frame(frame16(11'h0F0, 4'b0011), 16);
        send_frame(frame16(11'h123, 4'b0110), 16);
        send_frame(frame16(11'h321, 4'b1001), 16);
        send_frame(frame16(11'h3C3, 4'b0101), 16);

        // R1 R2: shift pulses with the select low are ignored.
        held = ser_out;
        for (int k = 0; k < 16; k++) begin
            @(negedge clk) ser_dat = 1'b1;
            wait_cyc(3);
            ser_clk = 1'b1;
            wait_cyc(4);
            ser_clk = 1'b0;
            wait_cyc(4);
        end
        check("R1", {63'h0, held}, {63'h0, ser_out});
        check_outputs("R2");
        send_frame(frame16(11'h6B5, 4'b0001), 16);

        // R9: reset in the middle of the run, then one more full frame.
        @(negedge clk) rst_n = 1'b0;
        wait_cyc(3);
        model_reset();
        check_outputs("R9");
        check("R9", {63'h0, ser_out}, 64'h0);
        @(negedge clk) rst_n = 1'b1;
        wait_cyc(4);
        send_frame(frame64(60'hFED_CBA9_8765_4321, 4'b0100), 64);

        done = 1;
        print_summary();
        $finish;
    end

endmodule